// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block executes one two-operand addition, `Rd <- Rd + source`, against a small register file that it owns. The source operand is found through one of ten addressing modes. Some modes need no memory at all. Others read one word or two words from data memory, and two of them also rewrite the base register. A small state machine puts these steps in order. A caller pulses `start` with the mode code and the instruction fields. It then watches the write port, which shows every register write, until `done` or `err` is raised.

Data memory is reached through one word-wide read port. The unit raises `mem_req` with an address and holds both until the memory returns `mem_valid` together with the data. The memory may take any number of cycles to answer. All address and data arithmetic wraps modulo 2^DW.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, register i holds 3*i (modulo 2^DW). `done`, `err`, `mem_req` and `wr_en` are all low.
- R2: Mode code 0 (register) adds register `rs_sel` to register `rd_sel` and makes no memory request. Count from the clock edge that samples `start`. The result write is shown on the write port in the second cycle after that edge, and `done` is high in the third.
- R3: Mode code 1 (immediate) adds `imm` to register `rd_sel`. It uses no memory and has the same timing as R2.
- R4: Four modes each make exactly one memory read and add the returned word. Code 2 reads at `R[rs]+imm`. Code 3 reads at `R[rs]`. Code 4 reads at `R[rs]+R[rx]`. Code 5 reads at `imm`.
- R5: Mode code 6 (memory indirect) reads at `R[rs]`. It then reads a second time, using the first returned word as the address, and adds the second word.
- R6: Mode code 7 (post-increment) reads at `R[rs]`. After the result write, it writes `R[rs]+dsz` to register `rs_sel` in the cycle where `done` is high.
- R7: Mode code 8 (pre-decrement) reads at `R[rs]-dsz`. After the result write, it writes that same value to register `rs_sel` in the cycle where `done` is high.
- R8: Mode code 9 (scaled) reads at `imm + R[rs] + R[rx]*dsz` and leaves every base register unchanged.
- R9: `mem_req` and `mem_addr` stay steady until a cycle in which `mem_valid` is high. The data is taken in that cycle.
- R10: Mode codes 10 to 15 raise `err` for the one cycle after `start` is sampled. They change no register, make no memory request and give no `done`.
- R11: `done` is a single-cycle pulse. A `start` that arrives while an operation is in progress is ignored.
- R12: In modes 7 and 8 with `rd_sel == rs_sel`, the result write comes first and the base update second, so the register ends up holding the updated base value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when the unit is idle |
| mode | input | 4 | Addressing-mode code |
| rd_sel | input | RA | Destination register number |
| rs_sel | input | RA | Source/base register number |
| rx_sel | input | RA | Index register number |
| imm | input | DW | Immediate, displacement or absolute address |
| dsz | input | SW | Operand size step / scale factor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_rdata | input | DW | Memory read data |
| mem_valid | input | 1 | Read data valid |
| done | output | 1 | Operation complete pulse |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | RA | Register being written |
| wr_data | output | DW | Value being written |
| err | output | 1 | Illegal mode code pulse |

## Verification
The assertions check several rules on every cycle. A request that is waiting must hold its address. `done` must fall after one cycle. `err` must never come with a write, a request or `done`. An illegal code must raise `err` and leave the unit idle, and the register and immediate modes must keep their fixed write-then-done timing. Only the bench's scenarios can show whether the computed addresses, the double read of the indirect mode, and the sums are correct. The same holds for the order and values of the base-register writeback when base and destination coincide, and for a busy-time `start` being ignored. All of these are compared against a register model kept in the bench while the memory answers with random delays.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [3:0] {
      AM_REG   = 4'd0,
      AM_IMM   = 4'd1,
      AM_DISP  = 4'd2,
      AM_RIND  = 4'd3,
      AM_INDEX = 4'd4,
      AM_ABS   = 4'd5,
      AM_MIND  = 4'd6,
      AM_AINC  = 4'd7,
      AM_ADEC  = 4'd8,
      AM_SCALE = 4'd9
   } am_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_MEM1,
      ST_MEM2,
      ST_WB,
      ST_DONE
   } st_e;

   localparam int unsigned AM_LAST = 9;

   function automatic logic am_legal(input logic [3:0] m);
      return (m <= 4'(AM_LAST));
   endfunction

   function automatic logic am_uses_mem(input logic [3:0] m);
      return (m >= 4'd2) && (m <= 4'(AM_LAST));
   endfunction

   function automatic logic am_auto(input logic [3:0] m);
      return (m == 4'd7) || (m == 4'd8);
   endfunction

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
   parameter int DW         = 16,
   parameter int RA         = 4,
   parameter int NRD        = 3,
   parameter int RST_STRIDE = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [RA-1:0]            widx,
   input  logic [DW-1:0]            wdata,
   input  logic [NRD-1:0][RA-1:0]   raddr,
   output logic [NRD-1:0][DW-1:0]   rdata
);
   localparam int NREG = 1 << RA;

   logic [DW-1:0] regs [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= DW'(RST_STRIDE * i);
      end else if (we) begin
         regs[widx] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rport
      assign rdata[p] = regs[raddr[p]];
   end

endmodule

// File: rtl/opf_agu.sv
module opf_agu
   import opf_pkg::*;
#(
   parameter int DW = 16,
   parameter int SW = 4
) (
   input  logic [3:0]    mode,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] idx,
   input  logic [DW-1:0] disp,
   input  logic [SW-1:0] dsz,
   output logic [DW-1:0] ea,
   output logic [DW-1:0] base_next
);
   logic [DW-1:0] dext;
   logic [DW-1:0] part [SW];
   logic [DW-1:0] scaled;

   assign dext = DW'(dsz);

   // shift-and-add product idx * dsz, one partial term per scale bit
   for (genvar g = 0; g < SW; g++) begin : g_part
      assign part[g] = dsz[g] ? (idx << g) : '0;
   end

   always_comb begin
      scaled = '0;
      for (int j = 0; j < SW; j++) scaled = scaled + part[j];
   end

   always_comb begin
      ea        = base;
      base_next = base;
      case (am_e'(mode))
         AM_DISP:  ea = base + disp;
         AM_RIND:  ea = base;
         AM_INDEX: ea = base + idx;
         AM_ABS:   ea = disp;
         AM_MIND:  ea = base;
         AM_AINC: begin
            ea        = base;
            base_next = base + dext;
         end
         AM_ADEC: begin
            ea        = base - dext;
            base_next = base - dext;
         end
         AM_SCALE: ea = disp + base + scaled;
         default:  ea = base;
      endcase
   end

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int DW = 16,
   parameter int RA = 4,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [RA-1:0] rd_sel,
   input  logic [RA-1:0] rs_sel,
   input  logic [RA-1:0] rx_sel,
   input  logic [DW-1:0] imm,
   input  logic [SW-1:0] dsz,
   input  logic          mem_valid,
   input  logic [DW-1:0] mem_rdata,
   input  logic [DW-1:0] agu_ea,
   input  logic [DW-1:0] agu_bnext,
   input  logic [DW-1:0] rs_val,
   input  logic [DW-1:0] rd_val,
   output logic [3:0]    mode_q,
   output logic [RA-1:0] rd_q,
   output logic [RA-1:0] rs_q,
   output logic [RA-1:0] rx_q,
   output logic [DW-1:0] imm_q,
   output logic [SW-1:0] dsz_q,
   output logic          mem_req,
   output logic [DW-1:0] mem_addr,
   output logic          we,
   output logic [RA-1:0] widx,
   output logic [DW-1:0] wdata,
   output logic          done,
   output logic          err,
   output logic          idle
);
   st_e           state_q, state_d;
   logic [DW-1:0] ptr_q;
   logic [DW-1:0] opnd_q;
   logic [DW-1:0] bnext_q;
   logic          err_q;
   logic          accept;

   assign accept = (state_q == ST_IDLE) && start && am_legal(mode);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept) state_d = ST_ADDR;
         ST_ADDR: state_d = am_uses_mem(mode_q) ? ST_MEM1 : ST_WB;
         ST_MEM1: if (mem_valid) state_d = (mode_q == 4'(AM_MIND)) ? ST_MEM2 : ST_WB;
         ST_MEM2: if (mem_valid) state_d = ST_WB;
         ST_WB:   state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         rd_q    <= '0;
         rs_q    <= '0;
         rx_q    <= '0;
         imm_q   <= '0;
         dsz_q   <= '0;
         ptr_q   <= '0;
         opnd_q  <= '0;
         bnext_q <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= (state_q == ST_IDLE) && start && !am_legal(mode);
         case (state_q)
            ST_IDLE: if (accept) begin
               mode_q <= mode;
               rd_q   <= rd_sel;
               rs_q   <= rs_sel;
               rx_q   <= rx_sel;
               imm_q  <= imm;
               dsz_q  <= dsz;
            end
            ST_ADDR: begin
               ptr_q   <= agu_ea;
               bnext_q <= agu_bnext;
               if (!am_uses_mem(mode_q))
                  opnd_q <= (mode_q == 4'(AM_REG)) ? rs_val : imm_q;
            end
            ST_MEM1: if (mem_valid) begin
               if (mode_q == 4'(AM_MIND)) ptr_q <= mem_rdata;
               else                       opnd_q <= mem_rdata;
            end
            ST_MEM2: if (mem_valid) opnd_q <= mem_rdata;
            default: ;
         endcase
      end
   end

   assign mem_req  = (state_q == ST_MEM1) || (state_q == ST_MEM2);
   assign mem_addr = ptr_q;
   assign we       = (state_q == ST_WB) || ((state_q == ST_DONE) && am_auto(mode_q));
   assign widx     = (state_q == ST_WB) ? rd_q : rs_q;
   assign wdata    = (state_q == ST_WB) ? (rd_val + opnd_q) : bnext_q;
   assign done     = (state_q == ST_DONE);
   assign err      = err_q;
   assign idle     = (state_q == ST_IDLE);

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
   parameter int DW         = 16,
   parameter int RA         = 4,
   parameter int SW         = 4,
   parameter int RST_STRIDE = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [RA-1:0] rd_sel,
   input  logic [RA-1:0] rs_sel,
   input  logic [RA-1:0] rx_sel,
   input  logic [DW-1:0] imm,
   input  logic [SW-1:0] dsz,
   output logic          mem_req,
   output logic [DW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_valid,
   output logic          done,
   output logic          wr_en,
   output logic [RA-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic          err
);
   localparam int NRD = 3;

   if (DW < 8 || DW > 64) begin : g_bad_dw
      $error("opfetch_unit: DW must lie in 8..64");
   end
   if (RA < 1 || RA > 6) begin : g_bad_ra
      $error("opfetch_unit: RA must lie in 1..6");
   end
   if (SW < 1 || SW > DW) begin : g_bad_sw
      $error("opfetch_unit: SW must lie in 1..DW");
   end

   logic [3:0]              mode_q;
   logic [RA-1:0]           rd_q, rs_q, rx_q;
   logic [DW-1:0]           imm_q;
   logic [SW-1:0]           dsz_q;
   logic [NRD-1:0][RA-1:0]  raddr;
   logic [NRD-1:0][DW-1:0]  rdata;
   logic [DW-1:0]           agu_ea, agu_bnext;
   logic                    ctl_idle;

   assign raddr[0] = rs_q;
   assign raddr[1] = rx_q;
   assign raddr[2] = rd_q;

   opf_regfile #(.DW(DW), .RA(RA), .NRD(NRD), .RST_STRIDE(RST_STRIDE)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .widx  (wr_idx),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (rdata)
   );

   opf_agu #(.DW(DW), .SW(SW)) u_agu (
      .mode      (mode_q),
      .base      (rdata[0]),
      .idx       (rdata[1]),
      .disp      (imm_q),
      .dsz       (dsz_q),
      .ea        (agu_ea),
      .base_next (agu_bnext)
   );

   opf_ctrl #(.DW(DW), .RA(RA), .SW(SW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .rd_sel    (rd_sel),
      .rs_sel    (rs_sel),
      .rx_sel    (rx_sel),
      .imm       (imm),
      .dsz       (dsz),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .agu_ea    (agu_ea),
      .agu_bnext (agu_bnext),
      .rs_val    (rdata[0]),
      .rd_val    (rdata[2]),
      .mode_q    (mode_q),
      .rd_q      (rd_q),
      .rs_q      (rs_q),
      .rx_q      (rx_q),
      .imm_q     (imm_q),
      .dsz_q     (dsz_q),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .we        (wr_en),
      .widx      (wr_idx),
      .wdata     (wr_data),
      .done      (done),
      .err       (err),
      .idle      (ctl_idle)
   );

endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [3:0]    mode,
   input logic          mem_req,
   input logic          mem_valid,
   input logic [DW-1:0] mem_addr,
   input logic          done,
   input logic          err,
   input logic          wr_en,
   input logic          idle
);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wr_en && !mem_req && !done);

   assert_illegal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && (mode > 4'd9) |=> err && idle);

   // R3 shares this timing with R2
   assert_fast_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idle && start && (mode <= 4'd1) |=> !wr_en ##1 wr_en ##1 done);

endmodule

bind opfetch_unit opf_checker #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .mem_req   (mem_req),
   .mem_valid (mem_valid),
   .mem_addr  (mem_addr),
   .done      (done),
   .err       (err),
   .wr_en     (wr_en),
   .idle      (ctl_idle)
);

// File: tb/opfetch_unit_tb.sv
`timescale 1ns/1ps
module opfetch_unit_tb;
   localparam int DW = 16;
   localparam int RA = 4;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [3:0]    mode;
   logic [RA-1:0] rd_sel, rs_sel, rx_sel;
   logic [DW-1:0] imm;
   logic [SW-1:0] dsz;
   logic          mem_req;
   logic [DW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic          mem_valid;
   logic          done, wr_en, err;
   logic [RA-1:0] wr_idx;
   logic [DW-1:0] wr_data;

   always #2 clk = ~clk;

   opfetch_unit #(.DW(DW), .RA(RA), .SW(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .rd_sel(rd_sel), .rs_sel(rs_sel), .rx_sel(rx_sel), .imm(imm), .dsz(dsz),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
      .done(done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .err(err)
   );

   int            n_chk = 0;
   int            n_fail = 0;
   logic [DW-1:0] m [16];
   logic [DW-1:0] alog [4];
   int            nlog;
   logic [DW-1:0] last_wdata;

   function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
      return (a * 16'd29) ^ 16'h3c5a;
   endfunction

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   // memory responder with random latency
   initial begin
      mem_valid = 1'b0;
      mem_rdata = '0;
      nlog = 0;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            repeat ($urandom % 3) @(negedge clk);
            if (nlog < 4) alog[nlog] = mem_addr;
            nlog++;
            mem_rdata = memf(mem_addr);
            mem_valid = 1'b1;
            @(negedge clk);
            mem_valid = 1'b0;
         end
      end
   end

   function automatic string rtag(input logic [3:0] md);
      case (md)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd6: return "R5";
         4'd7: return "R6";
         4'd8: return "R7";
         4'd9: return "R8";
         default: return "R4";
      endcase
   endfunction

   task automatic do_op(input logic [3:0] md, input logic [3:0] d_, input logic [3:0] s_,
                        input logic [3:0] x_, input logic [DW-1:0] im, input logic [3:0] dz,
                        input bit poke, input string note);
      logic [DW-1:0] base, idx, a0, a1, opnd, upd, expres;
      int naddr, nw, cyc, dcyc;
      int wc [2];
      logic [RA-1:0] wi [2];
      logic [DW-1:0] wd [2];
      bit autom, gotd, errseen;
      string t;
      t = {rtag(md), note};
      base = m[s_]; idx = m[x_];
      a0 = '0; a1 = '0; upd = base; naddr = 1; opnd = '0;
      autom = (md == 4'd7) || (md == 4'd8);
      case (md)
         4'd0: begin opnd = base; naddr = 0; end
         4'd1: begin opnd = im;   naddr = 0; end
         4'd2: a0 = base + im;
         4'd3: a0 = base;
         4'd4: a0 = base + idx;
         4'd5: a0 = im;
         4'd6: begin a0 = base; a1 = memf(a0); naddr = 2; end
         4'd7: begin a0 = base; upd = base + DW'(dz); end
         4'd8: begin a0 = base - DW'(dz); upd = a0; end
         default: a0 = im + base + idx * DW'(dz);
      endcase
      if (naddr == 1) opnd = memf(a0);
      if (naddr == 2) opnd = memf(a1);
      expres = m[d_] + opnd;

      @(negedge clk);
      nlog = 0;
      start = 1'b1; mode = md; rd_sel = d_; rs_sel = s_; rx_sel = x_; imm = im; dsz = dz;
      @(negedge clk);
      start = 1'b0;
      cyc = 1; nw = 0; gotd = 0; dcyc = 0; errseen = 0;
      wc[0] = 0; wc[1] = 0; wi[0] = '0; wi[1] = '0; wd[0] = '0; wd[1] = '0;
      while (!gotd && cyc < 80) begin
         if (poke && cyc == 1) begin start = 1'b1; mode = 4'hF; end
         if (poke && cyc == 2) start = 1'b0;
         if (err) errseen = 1;
         if (wr_en) begin
            if (nw < 2) begin wc[nw] = cyc; wi[nw] = wr_idx; wd[nw] = wr_data; end
            nw++;
         end
         if (done) begin gotd = 1; dcyc = cyc; end
         else begin @(negedge clk); cyc++; end
      end
      chk({t, " done reached"}, 64'(gotd), 64'd1);
      chk({t, " write count"}, 64'(nw), autom ? 64'd2 : 64'd1);
      chk({t, " result index"}, 64'(wi[0]), 64'(d_));
      chk({t, " result value"}, 64'(wd[0]), 64'(expres));
      chk({t, " result one cycle before done"}, 64'(wc[0]), 64'(dcyc - 1));
      if (autom) begin
         chk({t, " R12 base index"}, 64'(wi[1]), 64'(s_));
         chk({t, " R12 base value"}, 64'(wd[1]), 64'(upd));
         chk({t, " R12 base write in done cycle"}, 64'(wc[1]), 64'(dcyc));
      end
      chk({t, " R9 read count"}, 64'(nlog), 64'(naddr));
      if (naddr >= 1) chk({t, " R9 first address"}, 64'(alog[0]), 64'(a0));
      if (naddr == 2) chk({t, " R9 second address"}, 64'(alog[1]), 64'(a1));
      if (naddr == 0) begin
         chk({t, " write latency"}, 64'(wc[0]), 64'd2);
         chk({t, " done latency"}, 64'(dcyc), 64'd3);
      end
      if (poke) chk({t, " R11 busy start ignored"}, 64'(errseen), 64'd0);
      last_wdata = wd[0];
      m[d_] = expres;
      if (autom) m[s_] = upd;
      @(negedge clk);
      chk({t, " R11 done pulse"}, 64'(done), 64'd0);
   endtask

   task automatic do_illegal(input logic [3:0] md, input logic [3:0] d_);
      @(negedge clk);
      nlog = 0;
      start = 1'b1; mode = md; rd_sel = d_; rs_sel = d_; rx_sel = d_; imm = 16'h1234; dsz = 4'd1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 err raised", 64'(err), 64'd1);
      chk("R10 no write", 64'(wr_en), 64'd0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 err one cycle", 64'(err), 64'd0);
         chk("R10 quiet outputs", 64'({wr_en, done, mem_req}), 64'd0);
      end
      chk("R10 no memory read", 64'(nlog), 64'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 16; i++) m[i] = DW'(3 * i);
      rst_n = 1'b0; start = 1'b0; mode = '0; rd_sel = '0; rs_sel = '0; rx_sel = '0;
      imm = '0; dsz = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs idle after reset", 64'({done, err, mem_req, wr_en}), 64'd0);

      // directed corner cases
      do_op(4'd0, 4'd1, 4'd2, 4'd0, 16'h0, 4'd0, 0, " reg");
      chk("R1 reset contents 3+6", 64'(last_wdata), 64'd9);
      do_op(4'd1, 4'd5, 4'd0, 4'd0, 16'hFFFF, 4'd0, 0, " imm wrap");
      do_op(4'd2, 4'd3, 4'd4, 4'd0, 16'h0100, 4'd0, 0, " disp");
      do_op(4'd3, 4'd6, 4'd7, 4'd0, 16'h0, 4'd0, 0, " rind");
      do_op(4'd4, 4'd8, 4'd9, 4'd10, 16'h0, 4'd0, 0, " index");
      do_op(4'd5, 4'd2, 4'd0, 4'd0, 16'hABCD, 4'd0, 0, " abs");
      do_op(4'd6, 4'd11, 4'd12, 4'd0, 16'h0, 4'd0, 0, " mind");
      do_op(4'd7, 4'd13, 4'd14, 4'd0, 16'h0, 4'd4, 0, " ainc");
      do_op(4'd8, 4'd15, 4'd0, 4'd0, 16'h0, 4'd2, 0, " adec wrap");
      do_op(4'd9, 4'd4, 4'd5, 4'd6, 16'h0040, 4'd8, 0, " scale");
      do_op(4'd7, 4'd9, 4'd9, 4'd0, 16'h0, 4'd15, 0, " R12 ainc rd==rs");
      do_op(4'd8, 4'd10, 4'd10, 4'd0, 16'h0, 4'd3, 0, " R12 adec rd==rs");
      do_op(4'd3, 4'd1, 4'd1, 4'd0, 16'h0, 4'd0, 1, " R11 poke");
      do_illegal(4'd10, 4'd3);
      do_illegal(4'd15, 4'd0);
      do_op(4'd0, 4'd0, 4'd3, 4'd0, 16'h0, 4'd0, 0, " R10 reg unchanged");

      // constrained random
      for (int n = 0; n < 150; n++) begin
         logic [3:0] md;
         md = 4'($urandom % 11);
         if (md == 4'd10) do_illegal(4'(10 + $urandom % 6), 4'($urandom));
         else do_op(md, 4'($urandom), 4'($urandom), 4'($urandom), 16'($urandom),
                    4'($urandom), ($urandom % 8) == 0, " rand");
      end

      summary();
      $finish;
   end

endmodule